// File: doc/BRIEF.md
# Dual-Bank Byte-Lane Memory Interface

This block sits between a 16-bit processor bus and two byte-wide memory banks. Even-addressed bytes live in the low bank and travel on data bits 7..0. Odd-addressed bytes live in the high bank and travel on data bits 15..8. Two active-low lane enables choose which banks take part in a transfer. With both enables low the transfer is a halfword. With only one low the transfer is a single byte.

Each bank has its own one-of-eight device selector. A selector can fire only when three things hold: its lane enable is low, the access is to memory space, and the top four address bits are all zero. Address bit 0 never reaches the devices. Bus bits 16..1 drive the shared device address. The shared active-low read and write commands go to every device. Storage is behavioural. Each device keeps 2^STORE_AW bytes, indexed by the low bits of the device address.

A read returns data combinationally in the same cycle as the read command, and a lane that is not selected returns zero. A write is committed on the rising clock edge. If both commands are asserted together, the write is blocked and an error pulse appears.

Top module: `mbi_dual_bank`

## Requirements
- R1: After reset every stored byte reads as zero and `err_o` is low.
- R2: Chip selects can be active only when `mem_sel` is 1 and `addr[23:20]` is 0; for any other access all bits of `cs_lo_n` and `cs_hi_n` are 1.
- R3: Inside the window, `cs_lo_n[k]` is 0 exactly when `lo_en_n` is 0 and k equals `addr[19:17]`, and `cs_hi_n[k]` follows the same rule with `hi_en_n`; at most one bit per bank is 0.
- R4: `dev_addr` equals `addr[16:1]` at all times; `addr[0]` drives no output.
- R5: The low bank carries even bytes on `wdata[7:0]`/`rdata[7:0]` and the high bank carries odd bytes on bits 15..8; with both lane enables low, a write stores both bytes.
- R6: A write changes only the bytes of lanes whose enable is 0, and only at the selected device; every other byte keeps its value.
- R7: While `rd_n` is 0, each selected lane returns its stored byte in the same cycle; unselected lanes, and all lanes while `rd_n` is 1, return zero.
- R8: `dev_oe_n` equals `rd_n`; `dev_we_n` equals `wr_n`, except that it is forced to 1 when `rd_n` and `wr_n` are both 0.
- R9: A cycle where `rd_n` and `wr_n` are both 0 leaves storage unchanged and makes `err_o` 1 for the following cycle only.
- R10: Each device stores 2^STORE_AW bytes (16 by default) at index `dev_addr[STORE_AW-1:0]`; device addresses differing only above that field alias to the same byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 24 | Byte address from the bus |
| hi_en_n | input | 1 | Active-low enable for the odd (high) lane |
| lo_en_n | input | 1 | Active-low enable for the even (low) lane |
| mem_sel | input | 1 | 1 = memory space, 0 = I/O space |
| rd_n | input | 1 | Active-low read command |
| wr_n | input | 1 | Active-low write command |
| wdata | input | 16 | Write data, both lanes |
| rdata | output | 16 | Read data, both lanes |
| dev_addr | output | 16 | Shared device address (bus bits 16..1) |
| cs_lo_n | output | 8 | Active-low device selects, low bank |
| cs_hi_n | output | 8 | Active-low device selects, high bank |
| dev_we_n | output | 1 | Shared active-low write enable to devices |
| dev_oe_n | output | 1 | Shared active-low output enable to devices |
| err_o | output | 1 | One-cycle pulse after a read/write command clash |

## Verification
A read and a write can be commanded in the same cycle. When that happens the read must still return the stored bytes, and the write must be dropped, with an error pulse in the next cycle. The random stream issues both commands together on a share of its cycles, and a directed case forces the clash on a location just written with a known value. The bench checks three things: that cycle's read data against its model, that the device write enable stays high, and that `err_o` rises on the next cycle. A later read then confirms the stored bytes kept their old value.

// File: rtl/mbi_pkg.sv
package mbi_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic {
        LANE_EVEN = 1'b0,
        LANE_ODD  = 1'b1
    } lane_e;

    typedef struct packed {
        logic err;
    } top_state_t;
endpackage

// File: rtl/mbi_lane_decode.sv
module mbi_lane_decode #(
    parameter int SEL_W = 3,
    localparam int NDEV = 1 << SEL_W
) (
    input  logic             en_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic [NDEV-1:0]  cs_n_o
);
    for (genvar g = 0; g < NDEV; g++) begin : g_out
        assign cs_n_o[g] = !(en_i && (sel_i == SEL_W'(g)));
    end
endmodule

// File: rtl/mbi_lane_store.sv
module mbi_lane_store #(
    parameter int NDEV     = 8,
    parameter int STORE_AW = 4,
    localparam int DEPTH   = 1 << STORE_AW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NDEV-1:0]     cs_n_i,
    input  logic [STORE_AW-1:0] idx_i,
    input  logic                we_i,
    input  logic                re_i,
    input  logic [7:0]          wdata_i,
    output logic [7:0]          rdata_o
);
    typedef struct packed {
        logic [NDEV-1:0][DEPTH-1:0][7:0] mem;
    } lane_state_t;

    lane_state_t st_d, st_q;
    logic [7:0]  rd_acc;

    always_comb begin
        st_d   = st_q;
        rd_acc = '0;
        for (int d = 0; d < NDEV; d++) begin
            if (!cs_n_i[d]) begin
                if (re_i) rd_acc = rd_acc | st_q.mem[d][idx_i];
                if (we_i) st_d.mem[d][idx_i] = wdata_i;
            end
        end
    end

    assign rdata_o = rd_acc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: with no write or no device selected, nothing in the lane moves
    a_r6_lane_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_i || (&cs_n_i)) |=> $stable(st_q));

    // R7: a lane that is not being read drives zero
    a_r7_lane_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!re_i || (&cs_n_i)) |-> (rdata_o == 8'h00));
endmodule

// File: rtl/mbi_dual_bank.sv
module mbi_dual_bank #(
    parameter int ADDR_W   = 24,
    parameter int DEV_AW   = 16,
    parameter int SEL_W    = 3,
    parameter int STORE_AW = 4,
    localparam int NDEV    = 1 << SEL_W,
    localparam int SEL_LSB = 1 + DEV_AW,
    localparam int WIN_LSB = SEL_LSB + SEL_W,
    localparam int WIN_W   = ADDR_W - WIN_LSB,
    localparam int DATA_W  = 2 * mbi_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              hi_en_n,
    input  logic              lo_en_n,
    input  logic              mem_sel,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [DEV_AW-1:0] dev_addr,
    output logic [NDEV-1:0]   cs_lo_n,
    output logic [NDEV-1:0]   cs_hi_n,
    output logic              dev_we_n,
    output logic              dev_oe_n,
    output logic              err_o
);
    import mbi_pkg::*;

    logic              in_win;
    logic              clash;
    logic              wr_ok;
    logic [1:0]        lane_en;
    logic [SEL_W-1:0]  dev_sel;
    top_state_t        st_d, st_q;

    assign in_win   = mem_sel && (addr[ADDR_W-1:WIN_LSB] == WIN_W'(0));
    assign dev_sel  = addr[WIN_LSB-1:SEL_LSB];
    assign dev_addr = addr[DEV_AW:1];
    assign clash    = !rd_n && !wr_n;
    assign wr_ok    = !wr_n && rd_n;
    assign dev_oe_n = rd_n;
    assign dev_we_n = !wr_ok;

    assign lane_en[LANE_EVEN] = in_win && !lo_en_n;
    assign lane_en[LANE_ODD]  = in_win && !hi_en_n;

    logic [1:0][NDEV-1:0] cs_n;

    for (genvar l = 0; l < 2; l++) begin : g_lane
        mbi_lane_decode #(.SEL_W(SEL_W)) u_dec (
            .en_i   (lane_en[l]),
            .sel_i  (dev_sel),
            .cs_n_o (cs_n[l])
        );

        mbi_lane_store #(.NDEV(NDEV), .STORE_AW(STORE_AW)) u_store (
            .clk     (clk),
            .rst_n   (rst_n),
            .cs_n_i  (cs_n[l]),
            .idx_i   (dev_addr[STORE_AW-1:0]),
            .we_i    (wr_ok),
            .re_i    (!rd_n),
            .wdata_i (wdata[l*BYTE_W +: BYTE_W]),
            .rdata_o (rdata[l*BYTE_W +: BYTE_W])
        );
    end

    assign cs_lo_n = cs_n[LANE_EVEN];
    assign cs_hi_n = cs_n[LANE_ODD];

    always_comb begin
        st_d     = st_q;
        st_d.err = clash;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err_o = st_q.err;

    // R2: outside the window no device is selected
    a_r2_no_select_outside: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_sel || (addr[ADDR_W-1:WIN_LSB] != WIN_W'(0))) |-> ((&cs_lo_n) && (&cs_hi_n)));

    // R3: at most one device per bank, and a disabled lane selects nothing
    a_r3_one_per_bank: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_lo_n) && $onehot0(~cs_hi_n));
    a_r3_lane_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_en_n |-> (&cs_lo_n)) and (hi_en_n |-> (&cs_hi_n)));

    // R8: device write enable held off during a command clash
    a_r8_clash_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n && !wr_n) |-> dev_we_n);

    // R9: a clash raises the error flag on the next cycle
    a_r9_err_after_clash: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n && !wr_n) |=> err_o);
    a_r9_err_only_after_clash: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_n || wr_n) |=> !err_o);
endmodule

// File: tb/mbi_dual_bank_test.sv
`timescale 1ns/1ps
module mbi_dual_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] addr = '0;
    logic        hi_en_n = 1'b1, lo_en_n = 1'b1, mem_sel = 1'b1;
    logic        rd_n = 1'b1, wr_n = 1'b1;
    logic [15:0] wdata = '0;
    logic [15:0] rdata, dev_addr;
    logic [7:0]  cs_lo_n, cs_hi_n;
    logic        dev_we_n, dev_oe_n, err_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [7:0] ref_mem [2][8][16];

    mbi_dual_bank uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .hi_en_n(hi_en_n), .lo_en_n(lo_en_n),
        .mem_sel(mem_sel), .rd_n(rd_n), .wr_n(wr_n), .wdata(wdata), .rdata(rdata),
        .dev_addr(dev_addr), .cs_lo_n(cs_lo_n), .cs_hi_n(cs_hi_n),
        .dev_we_n(dev_we_n), .dev_oe_n(dev_oe_n), .err_o(err_o)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_cs(input bit en, input logic [2:0] sel);
        logic [7:0] v = 8'hFF;
        if (en) v[sel] = 1'b0;
        return v;
    endfunction

    function automatic bit exp_win(input logic [23:0] a, input bit m);
        return m && (a[23:20] == 4'h0);
    endfunction

    // one bus cycle: drive on the falling edge, check combinational outputs,
    // then check registered effects just after the rising edge
    task automatic cyc(input logic [23:0] a, input bit bh, input bit bl, input bit m,
                       input bit rd, input bit wr, input logic [15:0] wd);
        bit win;
        logic [2:0] dv;
        logic [3:0] ix;
        logic [15:0] er;
        @(negedge clk);
        addr = a; hi_en_n = bh; lo_en_n = bl; mem_sel = m;
        rd_n = !rd; wr_n = !wr; wdata = wd;
        #2;
        win = exp_win(a, m);
        dv  = a[19:17];
        ix  = a[4:1];
        chk("R2 R3 cs_lo_n", {24'h0, cs_lo_n}, {24'h0, exp_cs(win && !bl, dv)});
        chk("R2 R3 cs_hi_n", {24'h0, cs_hi_n}, {24'h0, exp_cs(win && !bh, dv)});
        chk("R4 dev_addr", {16'h0, dev_addr}, {16'h0, a[16:1]});
        chk("R8 dev_oe_n", {31'h0, dev_oe_n}, {31'h0, !rd});
        chk("R8 dev_we_n", {31'h0, dev_we_n}, {31'h0, !(wr && !rd)});
        er = '0;
        if (rd && win) begin
            if (!bl) er[7:0]  = ref_mem[0][dv][ix];
            if (!bh) er[15:8] = ref_mem[1][dv][ix];
        end
        chk("R5 R7 R10 rdata", {16'h0, rdata}, {16'h0, er});
        @(posedge clk);
        #1;
        if (wr && !rd && win) begin
            if (!bl) ref_mem[0][dv][ix] = wd[7:0];
            if (!bh) ref_mem[1][dv][ix] = wd[15:8];
        end
        chk("R9 err_o", {31'h0, err_o}, {31'h0, rd && wr});
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < 2; b++)
            for (int d = 0; d < 8; d++)
                for (int i = 0; i < 16; i++)
                    ref_mem[b][d][i] = 8'h00;
        void'($urandom(32'h5A17));
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 err_o after reset", {31'h0, err_o}, 32'h0);
        cyc(24'h000000, 0, 0, 1, 1, 0, 16'h0);
        cyc(24'h0E001E, 0, 0, 1, 1, 0, 16'h0);

        // R5: halfword write, then read
        cyc(24'h000104, 0, 0, 1, 0, 1, 16'hBEEF);
        cyc(24'h000104, 0, 0, 1, 1, 0, 16'h0);
        // R6: odd-only byte write keeps the even byte
        cyc(24'h000105, 0, 1, 1, 0, 1, 16'h5AAA);
        cyc(24'h000104, 0, 0, 1, 1, 0, 16'h0);
        // R6: even-only byte write on another device
        cyc(24'h060008, 1, 0, 1, 0, 1, 16'h7733);
        cyc(24'h060008, 0, 0, 1, 1, 0, 16'h0);
        // R10: alias above the stored index field
        cyc(24'h000006, 0, 0, 1, 0, 1, 16'h1234);
        cyc(24'h000026, 0, 0, 1, 1, 0, 16'h0);
        // R2: writes outside the window or to I/O space change nothing
        cyc(24'h100006, 0, 0, 1, 0, 1, 16'hDEAD);
        cyc(24'h000006, 0, 0, 0, 0, 1, 16'hDEAD);
        cyc(24'h000006, 0, 0, 1, 1, 0, 16'h0);
        // R9: command clash leaves storage alone and pulses the flag
        cyc(24'h000006, 0, 0, 1, 1, 1, 16'hFFFF);
        cyc(24'h000006, 0, 0, 1, 1, 0, 16'h0);
        // R7: no read command, no data
        cyc(24'h000006, 0, 0, 1, 0, 0, 16'h0);
        // R3: no lane enabled selects nothing
        cyc(24'h020000, 1, 1, 1, 1, 0, 16'h0);

        for (int n = 0; n < 600; n++) begin
            logic [23:0] a;
            int op;
            bit rd, wr;
            a = ($urandom_range(0, 9) < 8) ? {4'h0, 20'($urandom)} : 24'($urandom);
            op = $urandom_range(0, 9);
            rd = (op < 4) || (op == 8);
            wr = (op >= 4 && op < 8) || (op == 8);
            cyc(a, 1'($urandom), 1'($urandom), ($urandom_range(0, 9) != 0),
                rd, wr, 16'($urandom));
        end

        @(negedge clk);
        rd_n = 1'b1; wr_n = 1'b1;
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule